// File: doc/BRIEF.md
# Half-Precision NaN Classifier and Quieter

This block looks at one 16-bit binary16 value and reports, in the same cycle, whether it is a quiet NaN or a signaling NaN. It also returns a quieted copy of the value and the unit's default NaN constant, so a floating-point datapath can clean up its operands before it uses them. When a signaling NaN arrives with a valid strobe, the block raises a one-cycle invalid indication that the surrounding exception logic can collect.

Two architectures disagree on what the most significant fraction bit means in a NaN. A compile-time parameter picks the convention. Under the common convention a set top fraction bit marks a quiet NaN, and quieting a signaling NaN simply sets that bit. Under the inverted convention a set top bit marks a signaling NaN, and quieting replaces the operand with the default NaN. A second parameter picks the default NaN pattern. Its automatic setting follows the convention. The block is purely combinational, with no internal state.

Top module: `hnan_unit`

## Requirements
- R1: The operand is split into a sign (bit 15), an exponent (bits 14:10) and a fraction (bits 9:0). Only a value whose exponent is all ones (0x1F) and whose fraction is nonzero can be classified as a NaN.
- R2: With CONV = CONV_TOP_QUIET, is_qnan is 1 exactly when the value is a NaN and fraction bit 9 is set. This is equivalent to a magnitude of at least 0x7E00.
- R3: With CONV = CONV_TOP_QUIET, is_snan is 1 exactly when bits 14:9 equal 0x3E and bits 8:0 are nonzero.
- R4: With CONV = CONV_TOP_SIGNAL, the two tests trade places. is_snan is 1 for a NaN with bit 9 set. is_qnan is 1 for a NaN with bit 9 clear.
- R5: Infinities (exponent 0x1F with a zero fraction), zeros, subnormals and normal numbers raise neither is_qnan nor is_snan.
- R6: With CONV = CONV_TOP_QUIET, a signaling NaN leaves the quieting path with bit 9 set, and its sign and other fraction bits are unchanged.
- R7: With CONV = CONV_TOP_SIGNAL, a signaling NaN leaves the quieting path as the default NaN.
- R8: Any value that is not a signaling NaN leaves the quieting path unchanged.
- R9: default_nan is selected by DNAN as follows. DNAN_POS_TOP gives 0x7E00. DNAN_NEG_TOP gives 0xFE00. DNAN_LOW_FILL gives 0x7DFF. DNAN_AUTO gives 0xFE00 under CONV_TOP_QUIET and 0x7DFF under CONV_TOP_SIGNAL.
- R10: invalid_strobe is 1 exactly when in_valid is 1 and is_snan is 1. While in_valid is 0, invalid_strobe stays 0 whatever the operand is.
- R11: is_qnan and is_snan are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_valid | input | 1 | Operand is presented this cycle |
| in_value | input | 16 | Half-precision operand |
| is_qnan | output | 1 | Operand is a quiet NaN |
| is_snan | output | 1 | Operand is a signaling NaN |
| quieted_value | output | 16 | Operand with any signaling NaN made quiet |
| default_nan | output | 16 | Default NaN constant for this build |
| invalid_strobe | output | 1 | Signaling NaN seen with in_valid high |

## Verification
The bench builds three copies of the block side by side. The first uses the common polarity with the automatic default, the second uses the inverted polarity with the automatic default, and the third uses the common polarity with DNAN_POS_TOP. Because of this, both quieting variants and three of the four default patterns can be checked in a single run. All 65536 operand encodings are swept through every copy against a reference model of the requirements. This covers the boundary between payload bit 9 and the lower payload bits, the sign-set NaNs, and the infinities, all under each polarity.

// File: rtl/hnan_pkg.sv
`timescale 1ns/1ps
package hnan_pkg;

    localparam int unsigned EXP_W  = 5;
    localparam int unsigned FRAC_W = 10;
    localparam int unsigned HALF_W = 1 + EXP_W + FRAC_W;
    localparam int unsigned TOP_FRAC_BIT = FRAC_W - 1;

    localparam logic [EXP_W-1:0]  EXP_ALL_ONES = '1;
    localparam logic [FRAC_W-1:0] FRAC_TOP_ONLY = {1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [FRAC_W-1:0] FRAC_LOW_FILL = {1'b0, {(FRAC_W-1){1'b1}}};

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  expo;
        logic [FRAC_W-1:0] frac;
    } half_t;

    typedef enum logic {
        CONV_TOP_QUIET  = 1'b0,
        CONV_TOP_SIGNAL = 1'b1
    } nan_conv_e;

    typedef enum logic [1:0] {
        DNAN_AUTO     = 2'd0,
        DNAN_POS_TOP  = 2'd1,
        DNAN_NEG_TOP  = 2'd2,
        DNAN_LOW_FILL = 2'd3
    } dnan_sel_e;

    typedef struct packed {
        logic is_nan;
        logic top_set;
        logic rest_nz;
        logic is_inf;
    } nan_feat_t;

    typedef struct packed {
        logic qnan;
        logic snan;
    } nan_class_t;

    function automatic half_t dnan_pattern(nan_conv_e conv, dnan_sel_e sel);
        half_t r;
        r.expo = EXP_ALL_ONES;
        case (sel)
            DNAN_POS_TOP: begin
                r.sign = 1'b0;
                r.frac = FRAC_TOP_ONLY;
            end
            DNAN_NEG_TOP: begin
                r.sign = 1'b1;
                r.frac = FRAC_TOP_ONLY;
            end
            DNAN_LOW_FILL: begin
                r.sign = 1'b0;
                r.frac = FRAC_LOW_FILL;
            end
            default: begin
                if (conv == CONV_TOP_SIGNAL) begin
                    r.sign = 1'b0;
                    r.frac = FRAC_LOW_FILL;
                end else begin
                    r.sign = 1'b1;
                    r.frac = FRAC_TOP_ONLY;
                end
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/hnan_feature_extract.sv
`timescale 1ns/1ps
module hnan_feature_extract
    import hnan_pkg::*;
(
    input  logic [EXP_W-1:0]  expo,
    input  logic [FRAC_W-1:0] frac,
    output nan_feat_t         feat
);
    logic exp_max;
    logic frac_nz;

    always_comb begin
        exp_max      = (expo == EXP_ALL_ONES);
        frac_nz      = |frac;
        feat.is_nan  = exp_max && frac_nz;
        feat.is_inf  = exp_max && !frac_nz;
        feat.top_set = frac[TOP_FRAC_BIT];
        feat.rest_nz = |frac[TOP_FRAC_BIT-1:0];
    end

    always_comb begin
        AST_NAN_INF_DISJOINT: assert (!(feat.is_nan && feat.is_inf)) else $error("nan and inf both set"); // R1
    end
endmodule

// File: rtl/hnan_classify.sv
`timescale 1ns/1ps
module hnan_classify
    import hnan_pkg::*;
#(
    parameter nan_conv_e CONV = CONV_TOP_QUIET
) (
    input  nan_feat_t  feat,
    output nan_class_t cls
);
    generate
        if (CONV == CONV_TOP_QUIET) begin : g_top_quiet
            always_comb begin
                cls.qnan = feat.is_nan && feat.top_set;
                cls.snan = feat.is_nan && !feat.top_set && feat.rest_nz;
            end
        end else begin : g_top_signal
            always_comb begin
                cls.snan = feat.is_nan && feat.top_set;
                cls.qnan = feat.is_nan && !feat.top_set && feat.rest_nz;
            end
        end
    endgenerate

    always_comb begin
        AST_INF_NOT_CLASSED: assert (!(feat.is_inf && (cls.qnan || cls.snan))) else $error("infinity classified as NaN"); // R5
        AST_CLASS_NEEDS_NAN: assert (!(cls.qnan || cls.snan) || feat.is_nan) else $error("non-NaN classified"); // R1
    end
endmodule

// File: rtl/hnan_quiet_path.sv
`timescale 1ns/1ps
module hnan_quiet_path
    import hnan_pkg::*;
#(
    parameter nan_conv_e CONV = CONV_TOP_QUIET
) (
    input  half_t operand,
    input  logic  snan,
    input  half_t dnan,
    output half_t result
);
    generate
        if (CONV == CONV_TOP_QUIET) begin : g_set_top
            always_comb begin
                result = operand;
                if (snan) begin
                    result.frac[TOP_FRAC_BIT] = 1'b1;
                end
            end
            always_comb begin
                AST_SET_TOP_KEEPS: assert (!snan || (result.frac[TOP_FRAC_BIT] && result.sign == operand.sign
                    && result.frac[TOP_FRAC_BIT-1:0] == operand.frac[TOP_FRAC_BIT-1:0])) else $error("quieting lost payload"); // R6
            end
        end else begin : g_use_default
            always_comb begin
                result = snan ? dnan : operand;
            end
            always_comb begin
                AST_SNAN_TO_DEFAULT: assert (!snan || result == dnan) else $error("quieting missed default"); // R7
            end
        end
    endgenerate
endmodule

// File: rtl/hnan_unit.sv
`timescale 1ns/1ps
module hnan_unit
    import hnan_pkg::*;
#(
    parameter nan_conv_e CONV = CONV_TOP_QUIET,
    parameter dnan_sel_e DNAN = DNAN_AUTO
) (
    input  logic              in_valid,
    input  logic [HALF_W-1:0] in_value,
    output logic              is_qnan,
    output logic              is_snan,
    output logic [HALF_W-1:0] quieted_value,
    output logic [HALF_W-1:0] default_nan,
    output logic              invalid_strobe
);
    localparam half_t DNAN_CONST = dnan_pattern(CONV, DNAN);

    half_t      operand;
    half_t      quieted;
    nan_feat_t  feat;
    nan_class_t cls;

    assign operand = half_t'(in_value);

    hnan_feature_extract u_feat (
        .expo (operand.expo),
        .frac (operand.frac),
        .feat (feat)
    );

    hnan_classify #(.CONV(CONV)) u_cls (
        .feat (feat),
        .cls  (cls)
    );

    hnan_quiet_path #(.CONV(CONV)) u_quiet (
        .operand (operand),
        .snan    (cls.snan),
        .dnan    (DNAN_CONST),
        .result  (quieted)
    );

    assign is_qnan        = cls.qnan;
    assign is_snan        = cls.snan;
    assign quieted_value  = quieted;
    assign default_nan    = DNAN_CONST;
    assign invalid_strobe = in_valid && cls.snan;

    always_comb begin
        AST_CLASS_EXCLUSIVE: assert (!(is_qnan && is_snan)) else $error("both NaN kinds"); // R11
        AST_STROBE_GATED: assert (!invalid_strobe || (in_valid && is_snan)) else $error("stray strobe"); // R10
        AST_PASS_UNCHANGED: assert (is_snan || quieted_value == in_value) else $error("non-snan altered"); // R8
    end
endmodule

// File: tb/test_hnan_unit.sv
`timescale 1ns/1ps
module test_hnan_unit;
    import hnan_pkg::*;

    logic        clk = 1'b0;
    logic        vld = 1'b0;
    logic [15:0] val = 16'h0000;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    logic        q_a, s_a, inv_a;
    logic [15:0] qv_a, dn_a;
    logic        q_b, s_b, inv_b;
    logic [15:0] qv_b, dn_b;
    logic        q_c, s_c, inv_c;
    logic [15:0] qv_c, dn_c;

    always #2 clk = ~clk;

    hnan_unit i_hnan_unit (
        .in_valid(vld), .in_value(val), .is_qnan(q_a), .is_snan(s_a),
        .quieted_value(qv_a), .default_nan(dn_a), .invalid_strobe(inv_a));

    hnan_unit #(.CONV(CONV_TOP_SIGNAL), .DNAN(DNAN_AUTO)) i_hnan_unit_inv (
        .in_valid(vld), .in_value(val), .is_qnan(q_b), .is_snan(s_b),
        .quieted_value(qv_b), .default_nan(dn_b), .invalid_strobe(inv_b));

    hnan_unit #(.CONV(CONV_TOP_QUIET), .DNAN(DNAN_POS_TOP)) i_hnan_unit_pos (
        .in_valid(vld), .in_value(val), .is_qnan(q_c), .is_snan(s_c),
        .quieted_value(qv_c), .default_nan(dn_c), .invalid_strobe(inv_c));

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s in=%h actual=%h expected=%h", tag, val, act, exp_v);
        end
    endtask

    task automatic apply(logic [15:0] v, logic valid);
        @(negedge clk);
        val = v;
        vld = valid;
        #1;
    endtask

    function automatic logic m_nan(logic [15:0] v);
        return (v[14:10] == 5'h1F) && (v[9:0] != 10'h000);
    endfunction
    function automatic logic m_q(logic [15:0] v, logic inv);
        return m_nan(v) && (inv ? !v[9] : v[9]);
    endfunction
    function automatic logic m_s(logic [15:0] v, logic inv);
        return m_nan(v) && (inv ? v[9] : !v[9]);
    endfunction

    task automatic t_idle_state;
        apply(16'h7C01, 1'b0);
        chk("R10 idle strobe std", {15'd0, inv_a}, 16'd0);
        chk("R10 idle strobe inv", {15'd0, inv_b}, 16'd0);
        chk("R3 snan flag idle", {15'd0, s_a}, 16'd1);
    endtask

    task automatic t_defaults;
        apply(16'h0000, 1'b0);
        chk("R9 auto std", dn_a, 16'hFE00);
        chk("R9 auto inv", dn_b, 16'h7DFF);
        chk("R9 pos top", dn_c, 16'h7E00);
    endtask

    task automatic t_std_classes;
        apply(16'h7E00, 1'b1);
        chk("R2 qnan 7E00", {q_a, s_a}, 2'b10);
        apply(16'h7DFF, 1'b1);
        chk("R3 snan 7DFF", {q_a, s_a}, 2'b01);
        apply(16'hFC80, 1'b1);
        chk("R3 snan neg FC80", {q_a, s_a, inv_a}, 3'b011);
        chk("R1 sign ignored class", {15'd0, m_s(16'hFC80, 1'b0)}, {15'd0, s_a});
    endtask

    task automatic t_inv_classes;
        apply(16'h7E00, 1'b1);
        chk("R4 inv snan 7E00", {q_b, s_b, inv_b}, 3'b011);
        apply(16'h7DFF, 1'b1);
        chk("R4 inv qnan 7DFF", {q_b, s_b, inv_b}, 3'b100);
    endtask

    task automatic t_non_nan;
        apply(16'h7C00, 1'b1);
        chk("R5 +inf std", {q_a, s_a, inv_a}, 3'b000);
        chk("R5 +inf inv", {q_b, s_b, inv_b}, 3'b000);
        chk("R8 +inf passes", qv_b, 16'h7C00);
        apply(16'hFC00, 1'b1);
        chk("R5 -inf", {q_a, s_a, q_b, s_b}, 4'b0000);
        apply(16'h3C00, 1'b1);
        chk("R5 one", {q_a, s_a, q_b, s_b}, 4'b0000);
        apply(16'h0001, 1'b1);
        chk("R5 subnormal", {q_a, s_a, q_b, s_b}, 4'b0000);
    endtask

    task automatic t_quieting;
        apply(16'hFD55, 1'b1);
        chk("R6 set bit9 keep payload", qv_a, 16'hFF55);
        chk("R7 inv passes qnan", qv_b, 16'hFD55);
        apply(16'h7E01, 1'b1);
        chk("R7 inv snan to default", qv_b, 16'h7DFF);
        chk("R8 std qnan unchanged", qv_a, 16'h7E01);
        apply(16'h7C01, 1'b1);
        chk("R6 minimal snan", qv_c, 16'h7E01);
    endtask

    task automatic t_sweep;
        for (int i = 0; i < 65536; i++) begin
            logic [15:0] v;
            logic [15:0] ea, eb;
            v = 16'(i);
            apply(v, i[0]);
            ea = m_s(v, 1'b0) ? (v | 16'h0200) : v;
            eb = m_s(v, 1'b1) ? 16'h7DFF : v;
            chk("R2 R3 sweep std", {14'd0, q_a, s_a}, {14'd0, m_q(v, 1'b0), m_s(v, 1'b0)});
            chk("R4 sweep inv", {14'd0, q_b, s_b}, {14'd0, m_q(v, 1'b1), m_s(v, 1'b1)});
            chk("R6 R8 sweep std quiet", qv_a, ea);
            chk("R7 R8 sweep inv quiet", qv_b, eb);
            chk("R10 sweep strobe", {13'd0, inv_a, inv_b, inv_c},
                {13'd0, i[0] & m_s(v, 1'b0), i[0] & m_s(v, 1'b1), i[0] & m_s(v, 1'b0)});
            chk("R11 sweep exclusive", {15'd0, (q_a & s_a) | (q_b & s_b)}, 16'd0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        t_idle_state();
        t_defaults();
        t_std_classes();
        t_inv_classes();
        t_non_nan();
        t_quieting();
        t_sweep();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule